// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block watches one bit of a free-running 64-bit time base that arrives from outside. A 2-bit period select picks which bit is watched; a slower bit gives a longer watchdog period. Each 0-to-1 transition of the watched bit is a watchdog tick.

The first tick sets a status flag, and if the interrupt enable is high, an interrupt is raised. Software services the event by writing 1 to the status clear input, which returns the watchdog to its first stage. If a second tick arrives while the status is still set and the reset enable is high, the block drives a reset request pulse of fixed length. After the pulse, the block returns to its initial state. With the reset enable low, a second tick leaves the status set and does nothing else.

Top module: `wdog_two_stage`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, stat_o, irq_o and wdt_rst_o are 0.
- R2: per_sel_i values 0, 1, 2 and 3 watch time base bits 17, 21, 25 and 29 (counted from bit 0 = LSB). Transitions on any other bit have no effect on stat_o.
- R3: A 0-to-1 transition of the watched bit, while the status is clear, sets stat_o from the clock edge at which the bit is first sampled high.
- R4: irq_o is high exactly when stat_o is high and irq_en_i is high. With irq_en_i low, the status is still set.
- R5: A stat_clr_i pulse (write-1-to-clear) clears a set status and re-arms the first stage. With the status already clear, stat_clr_i has no effect.
- R6: A tick while the status is set, with stat_clr_i low and rst_en_i high, raises wdt_rst_o at that same clock edge. wdt_rst_o then stays high for exactly 16 clock cycles.
- R7: During the reset pulse, ticks and stat_clr_i are ignored and stat_o stays 1. When the pulse ends, stat_o is 0. The next tick is again a first-stage event.
- R8: A tick while the status is set, with rst_en_i low, leaves stat_o at 1 and never raises wdt_rst_o.
- R9: A change of per_sel_i loads the newly selected bit as its previous value, so a bit that is already high gives no tick. The same holds for a watched bit that is high when reset is released.
- R10: Holding the watched bit high, and its 1-to-0 transition, produce no tick.
- R11: A tick in the same cycle as stat_clr_i, while the status is set, counts as a new first-stage event. stat_o stays 1 and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbase_i | input | 64 | External time base |
| per_sel_i | input | 2 | Period select (watched bit) |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| rst_en_i | input | 1 | Reset request enable |
| stat_clr_i | input | 1 | Write-1-to-clear of the status |
| stat_o | output | 1 | Watchdog status flag |
| irq_o | output | 1 | Watchdog interrupt |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
If the stage state is wrong, it shows on stat_o at the very next clock edge after a tick or a clear. A missing or extra escalation shows on wdt_rst_o in that same cycle. A corrupted previous-bit register shows up as a status set one cycle after a select change or after reset release, where none is due. A fault in the pulse counter changes the measured high time of wdt_rst_o from 16 cycles, and it also leaves stat_o set after the pulse ends.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_RESET = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_tap_edge.sv
module wdog_tap_edge #(
  parameter int TB_W     = 64,
  parameter int SEL_W    = 2,
  parameter int TAP_LO   = 17,
  parameter int TAP_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int N_TAP = 1 << SEL_W;

  logic [N_TAP-1:0] taps;
  logic             unused_tbase;
  logic             sel_bit;
  logic [SEL_W-1:0] sel_q;
  logic             prev_q, vld_q;

  for (genvar gi = 0; gi < N_TAP; gi++) begin : g_tap
    assign taps[gi] = tbase_i[TAP_LO + gi*TAP_STEP];
  end

  assign unused_tbase = ^tbase_i;
  assign sel_bit      = taps[sel_i];

  // previous value is reloaded every cycle, so a select change cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      prev_q <= sel_bit;
      vld_q  <= 1'b1;
    end
  end

  assign tick_o = vld_q & (sel_q == sel_i) & sel_bit & ~prev_q;
endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic rst_en_i,
  input  logic done_i,
  output logic stat_o,
  output logic fire_o
);
  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    unique case (state_q)
      WD_IDLE:  if (tick_i) state_d = WD_ARMED;
      WD_ARMED: begin
        if (clr_i && !tick_i) begin
          state_d = WD_IDLE;
        end else if (tick_i && !clr_i && rst_en_i) begin
          state_d = WD_RESET;
          fire_o  = 1'b1;
        end
      end
      WD_RESET: if (done_i) state_d = WD_IDLE;
      default:  state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WD_IDLE;
    else         state_q <= state_d;
  end

  assign stat_o = (state_q != WD_IDLE);

  AST_STAT_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o) |-> ($past(clr_i) || $past(done_i))); // R5
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rst_o,
  output logic done_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= CW'(LEN - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_o  = act_q;
  assign done_o = act_q && (cnt_q == '0);

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !rst_o); // R7
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int TB_W     = 64,
  parameter int SEL_W    = 2,
  parameter int TAP_LO   = 17,
  parameter int TAP_STEP = 4,
  parameter int RST_LEN  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic [SEL_W-1:0] per_sel_i,
  input  logic             irq_en_i,
  input  logic             rst_en_i,
  input  logic             stat_clr_i,
  output logic             stat_o,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  localparam int RW = $clog2(RST_LEN + 1) + 1;

  logic tick, fire, done;

  wdog_tap_edge #(
    .TB_W(TB_W), .SEL_W(SEL_W), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)
  ) u_tap (
    .clk_i(clk_i), .rst_ni(rst_ni), .tbase_i(tbase_i), .sel_i(per_sel_i), .tick_o(tick)
  );

  wdog_stage_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(stat_clr_i),
    .rst_en_i(rst_en_i), .done_i(done), .stat_o(stat_o), .fire_o(fire)
  );

  wdog_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(fire), .rst_o(wdt_rst_o), .done_o(done)
  );

  assign irq_o = stat_o & irq_en_i;

  // checker: consecutive high cycles of the reset request
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (wdt_rst_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  AST_RST_LEN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (run_q < RW'(RST_LEN))); // R6
  AST_RST_LEN_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (run_q == RW'(RST_LEN))); // R6
  AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> ($past(rst_en_i) && $past(stat_o))); // R8
  AST_RST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> !stat_o); // R7
  AST_STAT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o) |-> $past(tick)); // R3
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tb_v = '0;
  logic [1:0]  per_sel = '0;
  logic        irq_en = 1'b0, rst_en = 1'b0, clr = 1'b0;
  logic        stat, irq, wrst;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wdog_two_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tbase_i(tb_v), .per_sel_i(per_sel),
    .irq_en_i(irq_en), .rst_en_i(rst_en), .stat_clr_i(clr),
    .stat_o(stat), .irq_o(irq), .wdt_rst_o(wrst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr   = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    tb_v = '1;
    rst_n = 1'b0;
    tick(2);
    chk("R1", "stat in reset", stat, 0);
    chk("R1", "irq in reset", irq, 0);
    chk("R1", "rst in reset", wrst, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "stat after release", stat, 0);
    tick(3);
    chk("R9", "bit high at release no tick", stat, 0);
    tb_v = '0;
    tick(1);
  endtask

  task automatic t_first_edge(input int sel);
    int tap;
    tap = 17 + 4*sel;
    irq_en = 1'b1; rst_en = 1'b0;
    per_sel = 2'(sel);
    tb_v = '0;
    do_reset();
    tick(1);
    tb_v[tap+1] = 1'b1;
    tb_v[tap-1] = 1'b1;
    tick(2);
    chk("R2", $sformatf("neighbour bits sel %0d", sel), stat, 0);
    tb_v[tap] = 1'b1;
    tick(1);
    chk("R3", $sformatf("status on tap %0d", tap), stat, 1);
    chk("R4", "irq with enable", irq, 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk("R5", "status cleared", stat, 0);
    tb_v = '0;
    tick(1);
  endtask

  task automatic t_irq_gate();
    irq_en = 1'b0; rst_en = 1'b0; per_sel = 2'd1; tb_v = '0;
    do_reset();
    tick(1);
    tb_v[21] = 1'b1;
    tick(1);
    chk("R4", "status with irq disabled", stat, 1);
    chk("R4", "irq gated off", irq, 0);
    irq_en = 1'b1;
    tick(1);
    chk("R4", "irq after enable", irq, 1);
  endtask

  task automatic t_no_rst();
    int hi;
    hi = 0;
    irq_en = 1'b1; rst_en = 1'b0; per_sel = 2'd2; tb_v = '0;
    do_reset();
    tick(1);
    tb_v[25] = 1'b1; tick(1);
    tb_v[25] = 1'b0; tick(1);
    tb_v[25] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (wrst) hi++;
    end
    chk("R8", "status stays set", stat, 1);
    chk("R8", "no reset cycles", hi, 0);
  endtask

  task automatic t_escalate();
    int hi;
    hi = 0;
    irq_en = 1'b1; rst_en = 1'b1; per_sel = 2'd0; tb_v = '0;
    do_reset();
    tick(1);
    tb_v[17] = 1'b1; tick(1);
    chk("R3", "first stage before escalation", stat, 1);
    chk("R6", "no reset on first tick", wrst, 0);
    tb_v[17] = 1'b0; tick(1);
    tb_v[17] = 1'b1; tick(1);
    chk("R6", "reset raised at second tick", wrst, 1);
    for (int i = 0; i < 40; i++) begin
      if (wrst) hi++;
      if (i == 1) begin clr = 1'b1; tb_v[17] = 1'b0; end
      if (i == 2) begin clr = 1'b0; tb_v[17] = 1'b1; end
      if (i == 4) chk("R7", "status held during pulse", stat, 1);
      tick(1);
    end
    chk("R6", "reset pulse length", hi, 16);
    chk("R7", "status clear after pulse", stat, 0);
    chk("R7", "irq clear after pulse", irq, 0);
    tb_v[17] = 1'b0; tick(1);
    tb_v[17] = 1'b1; tick(1);
    chk("R7", "first stage again", stat, 1);
    chk("R7", "no reset on new first tick", wrst, 0);
  endtask

  task automatic t_sel_change();
    irq_en = 1'b0; rst_en = 1'b1; per_sel = 2'd0; tb_v = '0;
    do_reset();
    tb_v[29] = 1'b1;
    tick(2);
    chk("R2", "unselected bit 29", stat, 0);
    per_sel = 2'd3;
    tick(3);
    chk("R9", "select change no false tick", stat, 0);
    tb_v[29] = 1'b0; tick(1);
    tb_v[29] = 1'b1; tick(1);
    chk("R9", "tick after select change", stat, 1);
  endtask

  task automatic t_hold_fall();
    irq_en = 1'b1; rst_en = 1'b1; per_sel = 2'd3; tb_v = '0;
    do_reset();
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R5", "clear while idle", stat, 0);
    tb_v[29] = 1'b1; tick(1);
    chk("R5", "tick after idle clear", stat, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    tick(10);
    chk("R10", "held high no tick", stat, 0);
    tb_v[29] = 1'b0;
    tick(3);
    chk("R10", "falling no tick", stat, 0);
    chk("R10", "no reset", wrst, 0);
  endtask

  task automatic t_clr_edge();
    irq_en = 1'b1; rst_en = 1'b1; per_sel = 2'd1; tb_v = '0;
    do_reset();
    tick(1);
    tb_v[21] = 1'b1; tick(1);
    tb_v[21] = 1'b0; tick(1);
    tb_v[21] = 1'b1; clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk("R11", "status after clear plus tick", stat, 1);
    chk("R11", "no reset on clear plus tick", wrst, 0);
    tick(2);
    chk("R11", "still no reset", wrst, 0);
  endtask

  initial begin
    tick(1);
    t_reset();
    for (int s = 0; s < 4; s++) t_first_edge(s);
    t_irq_gate();
    t_no_rst();
    t_escalate();
    t_sel_change();
    t_hold_fall();
    t_clr_edge();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule